// File: doc/BRIEF.md
# DRAM Refresh Cycle Controller

This block decides when a small CPU bus should run a dynamic-RAM refresh cycle and runs it. An interval timer raises a refresh request at a programmable period. The request is held until the CPU sequencer signals a machine-cycle end at which the bus is free for the refresh. The refresh cycle is then driven on `rfsh_strobe` for two or three clocks. A 7-bit row address counter is presented on `rfsh_addr` and advances once for each refresh cycle that completes.

A 4-bit control word sets the behaviour. It holds an enable bit, a stretch bit that adds one wait clock to every refresh cycle, and a 2-bit period select. Four conditions hold back insertion, and each treats a request differently. While the bus is granted away, requests are discarded but the timer keeps running. During sleep, one request is retained and issued at the first machine-cycle end after sleep ends. During wait states the request stays pending.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the strobe is low and the address is 0. The control word resets to enabled, stretch on and period select 00. With `mcycle_end` held high, the first strobe rises 11 clocks after reset release, and strobes then repeat every 10 clocks.
- R2: A refresh cycle keeps `rfsh_strobe` high for 3 clocks when the stretch bit (`cfg_wdata[2]`) is 1 and for 2 clocks when it is 0.
- R3: The period select (`cfg_wdata[1:0]`) sets the request period: 00 = 10, 01 = 20, 10 = 40, 11 = 80 clocks.
- R4: A refresh cycle starts only in a clock where `mcycle_end` is high, `bus_released`, `sleep` and `wait_st` are all low, and no refresh cycle is running. The strobe rises one clock later. `rfsh_busy` is high whenever a request is pending or a cycle is running.
- R5: While `bus_released` is high, no refresh starts and timer requests are discarded, while the timer keeps counting. The first strobe after the bus returns lies a whole number of periods after the last strobe before it.
- R6: While `sleep` is high, no refresh starts and a single request is retained; further requests merge into it. After sleep ends, exactly one refresh begins at the first `mcycle_end` pulse, with the strobe high in the following clock.
- R7: A request raised during wait states stays pending. When `wait_st` falls with `mcycle_end` high, the strobe rises in the next clock.
- R8: The address advances by one at the end of each completed refresh cycle, never for dropped requests, and wraps from 127 to 0.
- R9: With the enable bit (`cfg_wdata[3]`) at 0, the timer is held at zero, any pending request is cleared, the strobe stays low and `rfsh_busy` is low. After re-enabling with `mcycle_end` high, the first strobe is seen 12 clocks after the clock in which the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 4 | Control word: [3] enable, [2] stretch, [1:0] period select |
| mcycle_end | input | 1 | Machine-cycle boundary pulse from the CPU sequencer |
| bus_released | input | 1 | Bus granted to an external requester |
| sleep | input | 1 | CPU in sleep mode |
| wait_st | input | 1 | Bus is in wait states |
| rfsh_strobe | output | 1 | High during a refresh cycle |
| rfsh_busy | output | 1 | Refresh pending or running, toward the bus sequencer |
| rfsh_addr | output | 7 | Refresh row address |

## Verification
A timer count that is off by one shows at the ports as a strobe period that differs from the selected one by one clock. It is visible within one interval, and the first-strobe timing after reset or after re-enable shows it too. A pending flag that is handled wrongly shows as one of three faults. A strobe may appear during bus release or sleep, a retained request may be missing after sleep or wait, or an extra refresh may run. All of these show within one period of the blocking input changing. A wrong address update shows as a gap or repeat between the addresses of two consecutive strobes. A wrap fault shows after at most 128 refreshes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef struct packed {
        logic       en;
        logic       stretch;
        logic [1:0] sel;
    } rfsh_ctl_t;

    localparam rfsh_ctl_t CTL_RESET = '{en: 1'b1, stretch: 1'b1, sel: 2'b00};

    function automatic rfsh_ctl_t ctl_from_bits(input logic [3:0] b);
        rfsh_ctl_t c;
        c.en      = b[3];
        c.stretch = b[2];
        c.sel     = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int BASE_PERIOD = 10,
    parameter int SEL_W       = 2,
    localparam int MAX_PERIOD = BASE_PERIOD << ((1 << SEL_W) - 1),
    localparam int TW         = $clog2(MAX_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t    st_q, st_d;
    logic [TW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = (TW'(BASE_PERIOD) << sel) - TW'(1);
        tick  = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rfsh_request_latch.sv
module rfsh_request_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic bus_released,
    input  logic sleep,
    input  logic wait_st,
    input  logic mcycle_end,
    input  logic cyc_active,
    output logic pend,
    output logic go
);

    typedef struct packed {
        logic pend;
    } req_state_t;

    req_state_t st_q, st_d;
    logic       blocked;

    always_comb begin
        st_d    = st_q;
        blocked = bus_released | sleep | wait_st | cyc_active;
        go      = en & st_q.pend & mcycle_end & ~blocked;
        if (!en || bus_released) begin
            st_d.pend = 1'b0;
        end else if (tick) begin
            st_d.pend = 1'b1;
        end else if (go) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/rfsh_cycle_seq.sv
module rfsh_cycle_seq #(
    parameter int ADDR_W = 7,
    localparam int LW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stretch,
    input  logic              go,
    output logic              active,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic              active;
        logic [LW-1:0]     left;
        logic [ADDR_W-1:0] addr;
    } seq_state_t;

    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (!en) begin
                st_d.active = 1'b0;
                st_d.left   = '0;
            end else if (st_q.left == '0) begin
                st_d.active = 1'b0;
                st_d.addr   = st_q.addr + ADDR_W'(1);
            end else begin
                st_d.left = st_q.left - LW'(1);
            end
        end else if (go) begin
            st_d.active = 1'b1;
            st_d.left   = stretch ? LW'(2) : LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign addr   = st_q.addr;

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int BASE_PERIOD = 10,
    parameter int ADDR_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_wdata,
    input  logic              mcycle_end,
    input  logic              bus_released,
    input  logic              sleep,
    input  logic              wait_st,
    output logic              rfsh_strobe,
    output logic              rfsh_busy,
    output logic [ADDR_W-1:0] rfsh_addr
);
    import rfsh_pkg::*;

    rfsh_ctl_t ctl_q, ctl_d;
    logic      tick, pend, go, active, cfg_en;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_wr) ctl_d = ctl_from_bits(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign cfg_en = ctl_q.en;

    rfsh_interval_timer #(.BASE_PERIOD(BASE_PERIOD), .SEL_W(2)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .sel(ctl_q.sel), .tick(tick)
    );

    rfsh_request_latch u_req (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .tick(tick),
        .bus_released(bus_released), .sleep(sleep), .wait_st(wait_st),
        .mcycle_end(mcycle_end), .cyc_active(active), .pend(pend), .go(go)
    );

    rfsh_cycle_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .stretch(ctl_q.stretch),
        .go(go), .active(active), .addr(rfsh_addr)
    );

    assign rfsh_strobe = active;
    assign rfsh_busy   = pend | active;

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              mcycle_end,
    input logic              bus_released,
    input logic              sleep,
    input logic              wait_st,
    input logic              rfsh_strobe,
    input logic              rfsh_busy,
    input logic [ADDR_W-1:0] rfsh_addr
);

    logic [3:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_len <= '0;
        else if (rfsh_strobe) run_len <= run_len + 4'd1;
        else                  run_len <= '0;
    end

    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rfsh_strobe) && cfg_en) |-> (run_len == 4'd2 || run_len == 4'd3));

    p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_strobe) |-> $past(mcycle_end && !bus_released && !sleep && !wait_st));

    p_busy_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_strobe |-> rfsh_busy);

    p_release_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_released && !rfsh_strobe) |=> !rfsh_strobe);

    p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !rfsh_strobe) |=> !rfsh_strobe);

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_st && !rfsh_strobe) |=> !rfsh_strobe);

    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_addr != $past(rfsh_addr)) |->
            (rfsh_addr == $past(rfsh_addr) + ADDR_W'(1) && $past(rfsh_strobe)));

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && $past(!cfg_en)) |-> (!rfsh_strobe && !rfsh_busy));

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .mcycle_end(mcycle_end),
    .bus_released(bus_released), .sleep(sleep), .wait_st(wait_st),
    .rfsh_strobe(rfsh_strobe), .rfsh_busy(rfsh_busy), .rfsh_addr(rfsh_addr)
);

// File: tb/dram_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = 4'd0;
    logic       mcycle_end = 1'b1;
    logic       bus_released = 1'b0;
    logic       sleep = 1'b0;
    logic       wait_st = 1'b0;
    logic       rfsh_strobe, rfsh_busy;
    logic [6:0] rfsh_addr;

    int errors = 0;
    int checks = 0;
    int cyc = 0, rises = 0, rise_cyc = 0, rise_addr = 0, run = 0, last_len = 0;
    logic prev = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .mcycle_end(mcycle_end), .bus_released(bus_released), .sleep(sleep),
        .wait_st(wait_st), .rfsh_strobe(rfsh_strobe), .rfsh_busy(rfsh_busy),
        .rfsh_addr(rfsh_addr)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rfsh_strobe && !prev) begin
            rises     = rises + 1;
            rise_cyc  = cyc;
            rise_addr = int'(rfsh_addr);
        end
        if (rfsh_strobe) run = run + 1;
        else if (prev) begin
            last_len = run;
            run      = 0;
        end
        prev = rfsh_strobe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cfg_write(input logic [3:0] v);
        tick();
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_wr    = 1'b0;
    endtask

    task automatic wait_rise(input string req);
        int r0 = rises;
        int k  = 0;
        while (rises == r0 && k < 400) begin
            tick();
            k++;
        end
        if (rises == r0) chk(1'b0, req, 0, 1);
    endtask

    task automatic wait_fall();
        for (int k = 0; k < 20 && rfsh_strobe; k++) tick();
    endtask

    task automatic period_of(input string req, output int p);
        int t0;
        wait_rise(req);
        t0 = rise_cyc;
        wait_rise(req);
        p = rise_cyc - t0;
    endtask

    task automatic t_reset();
        int p;
        ticks(4);
        chk(rfsh_strobe == 1'b0, "R1 strobe in reset", int'(rfsh_strobe), 0);
        chk(rfsh_addr == 7'd0, "R1 addr in reset", int'(rfsh_addr), 0);
        rst_n = 1'b1;
        ticks(10);
        chk(rfsh_strobe == 1'b0, "R1 no strobe before 11", int'(rfsh_strobe), 0);
        tick();
        chk(rfsh_strobe == 1'b1, "R1 first strobe at 11", int'(rfsh_strobe), 1);
        chk(rfsh_addr == 7'd0, "R1 first address", int'(rfsh_addr), 0);
        wait_fall();
        chk(last_len == 3, "R1 R2 reset length", last_len, 3);
        period_of("R1 period", p);
        chk(p == 10, "R1 reset period", p, 10);
    endtask

    task automatic t_addr_wrap();
        int bad = 0;
        int wraps = 0;
        int pa;
        wait_rise("R8 start");
        pa = rise_addr;
        for (int i = 0; i < 130; i++) begin
            wait_rise("R8 run");
            if (rise_addr != ((pa + 1) % 128)) bad++;
            if (pa == 127 && rise_addr == 0) wraps++;
            pa = rise_addr;
        end
        chk(bad == 0, "R8 address steps by one", bad, 0);
        chk(wraps == 1, "R8 wrap 127 to 0", wraps, 1);
    endtask

    task automatic t_stretch();
        cfg_write(4'b1000);
        wait_rise("R2 short");
        wait_fall();
        chk(last_len == 2, "R2 length without stretch", last_len, 2);
        cfg_write(4'b1100);
        wait_rise("R2 long");
        wait_fall();
        chk(last_len == 3, "R2 length with stretch", last_len, 3);
    endtask

    task automatic t_interval();
        int p;
        for (int s = 1; s < 4; s++) begin
            cfg_write({2'b11, 2'(s)});
            wait_rise("R3 settle");
            period_of("R3 period", p);
            chk(p == (10 << s), "R3 period select", p, 10 << s);
        end
        cfg_write(4'b1100);
        wait_rise("R3 settle");
        period_of("R3 period", p);
        chk(p == 10, "R3 period select 00", p, 10);
    endtask

    task automatic t_wait();
        int r0;
        wait_rise("R7 sync");
        wait_fall();
        tick();
        wait_st = 1'b1;
        r0 = rises;
        ticks(25);
        chk(rises == r0, "R7 no strobe in wait", rises - r0, 0);
        chk(rfsh_busy == 1'b1, "R7 R4 busy while pending", int'(rfsh_busy), 1);
        wait_st = 1'b0;
        tick();
        chk(rfsh_strobe == 1'b1, "R7 R4 strobe next clock", int'(rfsh_strobe), 1);
        chk(rises == r0 + 1, "R7 one refresh", rises - r0, 1);
    endtask

    task automatic t_sleep();
        int r0, a0;
        wait_fall();
        tick();
        sleep = 1'b1;
        r0 = rises;
        ticks(45);
        chk(rises == r0, "R6 no strobe in sleep", rises - r0, 0);
        a0 = int'(rfsh_addr);
        mcycle_end = 1'b0;
        sleep      = 1'b0;
        ticks(3);
        chk(rfsh_strobe == 1'b0, "R6 R4 waits for boundary", int'(rfsh_strobe), 0);
        mcycle_end = 1'b1;
        tick();
        mcycle_end = 1'b0;
        chk(rfsh_strobe == 1'b1, "R6 strobe after boundary", int'(rfsh_strobe), 1);
        ticks(5);
        chk(rises == r0 + 1, "R6 one retained refresh", rises - r0, 1);
        chk(int'(rfsh_addr) == (a0 + 1) % 128, "R6 R8 address", int'(rfsh_addr), (a0 + 1) % 128);
        mcycle_end = 1'b1;
    endtask

    task automatic t_release();
        int r0, t0, a0;
        wait_rise("R5 sync");
        t0 = rise_cyc;
        a0 = rise_addr;
        tick();
        bus_released = 1'b1;
        r0 = rises;
        ticks(37);
        chk(rises == r0, "R5 no strobe while released", rises - r0, 0);
        bus_released = 1'b0;
        wait_rise("R5 after release");
        chk(((rise_cyc - t0) % 10) == 0, "R5 timer phase kept", (rise_cyc - t0) % 10, 0);
        chk(rise_addr == (a0 + 1) % 128, "R5 R8 no skipped address", rise_addr, (a0 + 1) % 128);
    endtask

    task automatic t_disable();
        int r0, a0;
        cfg_write(4'b0100);
        ticks(3);
        r0 = rises;
        a0 = int'(rfsh_addr);
        ticks(100);
        chk(rises == r0, "R9 no strobe when off", rises - r0, 0);
        chk(int'(rfsh_addr) == a0, "R9 address held", int'(rfsh_addr), a0);
        chk(rfsh_busy == 1'b0, "R9 busy low when off", int'(rfsh_busy), 0);
        cfg_write(4'b1100);
        ticks(10);
        chk(rfsh_strobe == 1'b0, "R9 timer restarts from zero", int'(rfsh_strobe), 0);
        tick();
        chk(rfsh_strobe == 1'b1, "R9 first strobe after enable", int'(rfsh_strobe), 1);
    endtask

    initial begin
        t_reset();
        t_addr_wrap();
        t_stretch();
        t_interval();
        t_wait();
        t_sleep();
        t_release();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule